// File: doc/BRIEF.md
# Sixty-Four Source Interrupt Controller

This block collects 64 active-low interrupt inputs and presents them to a processor through a small register file of 32-bit words. Every source has one enable bit and one status bit. These bits sit in a "high" word or a "low" word at scattered positions that follow a fixed map. Software unmasks sources through the two enable words and acknowledges edge events by writing ones to the status words. It reads a vector word to find which source to service first.

Most sources are internal. They are level sensitive and always report the live state of their input. Sources 19 to 25 are external lines. A select bit makes each of them either level sensitive or sensitive to falling edges. Sources 48 to 63 are port lines. They always latch edges, and a select bit picks falling-only or both-edge detection. One request line, `irq_o`, is high while any unmasked source is pending.

Top module: `intc64`

## Requirements
- R1: Enable words (address 0 = high, address 1 = low) reset to zero. A 1 bit enables its source(s). `irq_o` stays low while no pending source is enabled.
- R2: Source s is in the low word when s[4]=1, and in the high word otherwise. Bit positions: s=0 uses bit 0. s=1..15 uses bit 16−s. s=16..18 uses bit 18−s. s=19..30 uses bit 33−s. s=31 uses bit 0. s=32..47 uses bit 63−s. s=48..63 uses bit s−32. A status bit shared by two sources reads as their OR.
- R3: A level source shows the live inverted input in its status bit (address 2 = high, address 3 = low). Writing a 1 to that bit has no effect.
- R4: The select word (address 4) resets to 0. Only bits 8..14 (external source s at bit 33−s) and bits 16..31 (port source s at bit s−32) hold a value. All other bits read 0.
- R5: An external source whose select bit is 1 sets its status bit on a high-to-low input transition, seen at the first clock edge after the change. The bit then holds until it is acknowledged, even after the input returns high.
- R6: A port source with select bit 1 latches on falling transitions only. With select bit 0 it latches on both rising and falling transitions.
- R7: Writing to a status word clears every latched source whose bit is written as 1. Bits written as 0 leave their sources unchanged.
- R8: When an edge is detected in the same cycle as an acknowledge of that source, the status bit stays set.
- R9: The vector word (address 5) carries, in bits 31:26, the lowest-numbered source in 1..63 that is both pending and enabled, or 0 when none is. Bits 25:0 read 0.
- R10: `irq_o` is high exactly when the vector field is non-zero.
- R11: Source 0 never raises `irq_o` and never appears in the vector, though its status bit still reports the live input.
- R12: Addresses 6 and 7 read as 0, and writes to them or to address 5 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_n_i | input | 64 | Interrupt inputs, active low, indexed by source number |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The collision that matters is between an edge capture and a software acknowledge of the same source in one clock cycle. The bench first latches a port source with a falling edge. Then, in one cycle, it raises the input (a rising edge in both-edge mode) and issues a write-one acknowledge for that bit. It judges the outcome from the status word read back afterwards: the bit must still be set. A second acknowledge with no new edge must then clear it.

// File: rtl/intc64_pkg.sv
package intc64_pkg;
  localparam int NSRC   = 64;
  localparam int WORD_W = 32;
  localparam int SRC_W  = $clog2(NSRC);
  localparam int ADDR_W = 3;
  localparam int VEC_LSB = WORD_W - SRC_W;

  localparam logic [ADDR_W-1:0] A_EN_HI   = 3'd0;
  localparam logic [ADDR_W-1:0] A_EN_LO   = 3'd1;
  localparam logic [ADDR_W-1:0] A_STAT_HI = 3'd2;
  localparam logic [ADDR_W-1:0] A_STAT_LO = 3'd3;
  localparam logic [ADDR_W-1:0] A_SEL     = 3'd4;
  localparam logic [ADDR_W-1:0] A_VEC     = 3'd5;

  typedef enum logic [1:0] {KIND_INT, KIND_EXT, KIND_PORT} src_kind_e;

  // 1 = low word
  function automatic logic src_word(int s);
    return s[4];
  endfunction

  function automatic int src_bit(int s);
    if (s == 0)      return 0;
    else if (s < 16) return 16 - s;
    else if (s < 19) return 18 - s;
    else if (s < 31) return 33 - s;
    else if (s == 31) return 0;
    else if (s < 48) return 63 - s;
    else             return s - 32;
  endfunction

  function automatic src_kind_e src_kind(int s);
    if (s >= 19 && s <= 25) return KIND_EXT;
    else if (s >= 48)       return KIND_PORT;
    else                    return KIND_INT;
  endfunction

  function automatic int sel_bit(int s);
    if (src_kind(s) == KIND_EXT)       return 33 - s;
    else if (src_kind(s) == KIND_PORT) return s - 32;
    else                               return 0;
  endfunction

  function automatic logic [WORD_W-1:0] sel_impl_mask();
    logic [WORD_W-1:0] m;
    m = '0;
    for (int s = 0; s < NSRC; s++)
      if (src_kind(s) != KIND_INT) m[sel_bit(s)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/intc64_capture.sv
module intc64_capture
  import intc64_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   src_n_i,
  input  logic [WORD_W-1:0] sel_i,
  input  logic [NSRC-1:0]   clr_i,
  output logic [NSRC-1:0]   pend_o,
  output logic [NSRC-1:0]   flag_o
);
  for (genvar s = 0; s < NSRC; s++) begin : g_src
    localparam src_kind_e KIND = src_kind(s);
    if (KIND == KIND_INT) begin : g_lvl
      assign pend_o[s] = ~src_n_i[s];
      assign flag_o[s] = 1'b0;
    end else begin : g_edge
      logic prev_q, flag_q, sel, fall, rise, hit;
      assign sel  = sel_i[sel_bit(s)];
      assign fall = prev_q & ~src_n_i[s];
      assign rise = ~prev_q & src_n_i[s];
      if (KIND == KIND_EXT) begin : g_ext
        assign hit       = sel & fall;
        assign pend_o[s] = sel ? flag_q : ~src_n_i[s];
      end else begin : g_port
        assign hit       = fall | (~sel & rise);
        assign pend_o[s] = flag_q;
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          prev_q <= 1'b1;
          flag_q <= 1'b0;
        end else begin
          prev_q <= src_n_i[s];
          if (hit)           flag_q <= 1'b1;   // capture beats acknowledge
          else if (clr_i[s]) flag_q <= 1'b0;
        end
      end
      assign flag_o[s] = flag_q;
    end
  end
endmodule

// File: rtl/intc64_wordmap.sv
module intc64_wordmap
  import intc64_pkg::*;
(
  input  logic [NSRC-1:0]   pend_i,
  input  logic [WORD_W-1:0] en_hi_i,
  input  logic [WORD_W-1:0] en_lo_i,
  input  logic              ack_hi_i,
  input  logic              ack_lo_i,
  input  logic [WORD_W-1:0] ack_data_i,
  output logic [WORD_W-1:0] stat_hi_o,
  output logic [WORD_W-1:0] stat_lo_o,
  output logic [NSRC-1:0]   en_o,
  output logic [NSRC-1:0]   clr_o
);
  for (genvar s = 0; s < NSRC; s++) begin : g_map
    localparam int  BIT = src_bit(s);
    localparam logic LO = src_word(s);
    if (LO) begin : g_lo
      assign en_o[s]  = en_lo_i[BIT];
      assign clr_o[s] = ack_lo_i & ack_data_i[BIT];
    end else begin : g_hi
      assign en_o[s]  = en_hi_i[BIT];
      assign clr_o[s] = ack_hi_i & ack_data_i[BIT];
    end
  end

  always_comb begin
    stat_hi_o = '0;
    stat_lo_o = '0;
    for (int s = 0; s < NSRC; s++) begin
      if (src_word(s)) stat_lo_o[src_bit(s)] = stat_lo_o[src_bit(s)] | pend_i[s];
      else             stat_hi_o[src_bit(s)] = stat_hi_o[src_bit(s)] | pend_i[s];
    end
  end
endmodule

// File: rtl/intc64_prio.sv
module intc64_prio
  import intc64_pkg::*;
(
  input  logic [NSRC-1:0]  req_i,
  output logic [SRC_W-1:0] vec_o,
  output logic             any_o
);
  // source 0 is reserved: vector 0 means idle
  always_comb begin
    vec_o = '0;
    for (int s = NSRC - 1; s >= 1; s--)
      if (req_i[s]) vec_o = SRC_W'(s);
  end
  assign any_o = |req_i[NSRC-1:1];
endmodule

// File: rtl/intc64.sv
module intc64
  import intc64_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   src_n_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam logic [WORD_W-1:0] SEL_IMPL = sel_impl_mask();

  logic [WORD_W-1:0] en_hi_q, en_lo_q, sel_q, stat_hi, stat_lo;
  logic [NSRC-1:0]   pend, en, clr, edge_flag;
  logic [SRC_W-1:0]  vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_hi_q <= '0;
      en_lo_q <= '0;
      sel_q   <= '0;
    end else if (wr_i) begin
      if (addr_i == A_EN_HI) en_hi_q <= wdata_i;
      if (addr_i == A_EN_LO) en_lo_q <= wdata_i;
      if (addr_i == A_SEL)   sel_q   <= wdata_i & SEL_IMPL;
    end
  end

  intc64_capture u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_n_i(src_n_i),
    .sel_i  (sel_q),
    .clr_i  (clr),
    .pend_o (pend),
    .flag_o (edge_flag)
  );

  intc64_wordmap u_map (
    .pend_i    (pend),
    .en_hi_i   (en_hi_q),
    .en_lo_i   (en_lo_q),
    .ack_hi_i  (wr_i && addr_i == A_STAT_HI),
    .ack_lo_i  (wr_i && addr_i == A_STAT_LO),
    .ack_data_i(wdata_i),
    .stat_hi_o (stat_hi),
    .stat_lo_o (stat_lo),
    .en_o      (en),
    .clr_o     (clr)
  );

  intc64_prio u_prio (
    .req_i(pend & en),
    .vec_o(vec),
    .any_o(irq_o)
  );

  always_comb begin
    case (addr_i)
      A_EN_HI:   rdata_o = en_hi_q;
      A_EN_LO:   rdata_o = en_lo_q;
      A_STAT_HI: rdata_o = stat_hi;
      A_STAT_LO: rdata_o = stat_lo;
      A_SEL:     rdata_o = sel_q;
      A_VEC:     rdata_o = {vec, {VEC_LSB{1'b0}}};
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/intc64_chk.sv
module intc64_chk
  import intc64_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NSRC-1:0]   src_n_i,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [WORD_W-1:0] rdata_o,
  input logic              irq_o,
  input logic [WORD_W-1:0] en_hi_i,
  input logic [WORD_W-1:0] en_lo_i,
  input logic [NSRC-1:0]   flag_i
);
  AST_ALL_MASKED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_hi_i == '0 && en_lo_i == '0) |-> !irq_o); // R1
  AST_LEVEL_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_STAT_HI) |-> (rdata_o[15] == !src_n_i[1])); // R3
  AST_SEL_UNUSED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_SEL) |-> (rdata_o[7:0] == 8'h0 && rdata_o[15] == 1'b0)); // R4
  AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && (addr_i == A_STAT_HI || addr_i == A_STAT_LO))
      |=> ((flag_i & $past(flag_i)) == $past(flag_i))); // R5
  AST_VEC_LOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_VEC) |-> (rdata_o[VEC_LSB-1:0] == '0)); // R9
  AST_IRQ_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_VEC) |-> (irq_o == (rdata_o[WORD_W-1:VEC_LSB] != '0))); // R10
endmodule

bind intc64 intc64_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .src_n_i(src_n_i),
  .wr_i   (wr_i),
  .addr_i (addr_i),
  .rdata_o(rdata_o),
  .irq_o  (irq_o),
  .en_hi_i(en_hi_q),
  .en_lo_i(en_lo_q),
  .flag_i (edge_flag)
);

// File: tb/intc64_bench.sv
`timescale 1ns/1ps
module intc64_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src_n = '1;
  logic        wr = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  intc64 u_intc64 (
    .clk_i(clk), .rst_ni(rst_n), .src_n_i(src_n), .wr_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // {source, low word, bit} taken from the R2 map
  localparam logic [11:0] MAP_TBL [10] = '{
    {6'd1,  1'b0, 5'd15}, {6'd15, 1'b0, 5'd1},  {6'd16, 1'b1, 5'd2},
    {6'd18, 1'b1, 5'd0},  {6'd20, 1'b1, 5'd13}, {6'd30, 1'b1, 5'd3},
    {6'd32, 1'b0, 5'd31}, {6'd47, 1'b0, 5'd16}, {6'd49, 1'b1, 5'd17},
    {6'd63, 1'b1, 5'd31}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0; wdata = '0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic set_src(input int s, input logic v);
    @(negedge clk); src_n[s] = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    rd_reg(3'd0, d); check("R1 en_hi reset", d, 32'h0);
    rd_reg(3'd1, d); check("R1 en_lo reset", d, 32'h0);
    rd_reg(3'd4, d); check("R4 sel reset", d, 32'h0);
    rd_reg(3'd5, d); check("R9 idle vector", d, 32'h0);
    check("R10 idle irq", {31'h0, irq}, 32'h0);

    // mapping table walk
    for (int i = 0; i < 10; i++) begin
      automatic int s = int'(MAP_TBL[i][11:6]);
      automatic logic lo = MAP_TBL[i][5];
      automatic int b = int'(MAP_TBL[i][4:0]);
      wr_reg({2'b00, lo}, 32'h1 << b);
      set_src(s, 1'b0);
      check($sformatf("R1 irq src %0d", s), {31'h0, irq}, 32'h1);
      rd_reg(3'd5, d); check($sformatf("R9 vector src %0d", s), d, 32'(s) << 26);
      rd_reg({2'b01, lo}, d); check($sformatf("R2 status bit src %0d", s), d, 32'h1 << b);
      set_src(s, 1'b1);
      wr_reg({2'b01, lo}, 32'h1 << b);
      wr_reg({2'b00, lo}, 32'h0);
      rd_reg({2'b01, lo}, d); check($sformatf("R7 cleared src %0d", s), d, 32'h0);
    end

    // R3: level source ignores acknowledge
    set_src(1, 1'b0);
    wr_reg(3'd2, 32'h0000_8000);
    rd_reg(3'd2, d); check("R3 level survives ack", d, 32'h0000_8000);
    set_src(1, 1'b1);
    rd_reg(3'd2, d); check("R3 level follows input", d, 32'h0);

    // R4: select word implemented bits
    wr_reg(3'd4, 32'hFFFF_FFFF);
    rd_reg(3'd4, d); check("R4 sel implemented bits", d, 32'hFFFF_7F00);
    wr_reg(3'd4, 32'h0002_2000);   // src 20 falling, src 49 falling-only
    rd_reg(3'd4, d); check("R4 sel readback", d, 32'h0002_2000);

    // R5: external falling edge latch
    set_src(20, 1'b0);
    set_src(20, 1'b1);
    rd_reg(3'd3, d); check("R5 ext edge latched", d, 32'h0000_2000);
    wr_reg(3'd3, 32'h0);
    rd_reg(3'd3, d); check("R7 zero write keeps", d, 32'h0000_2000);
    wr_reg(3'd3, 32'h0000_2000);
    rd_reg(3'd3, d); check("R7 ack clears ext", d, 32'h0);

    // R6: port falling-only ignores rising
    set_src(49, 1'b0);
    wr_reg(3'd3, 32'h0002_0000);
    set_src(49, 1'b1);
    rd_reg(3'd3, d); check("R6 falling-only no rise", d, 32'h0);
    // R6: both-edge mode sees rising
    wr_reg(3'd4, 32'h0000_2000);
    set_src(49, 1'b0);
    wr_reg(3'd3, 32'h0002_0000);
    rd_reg(3'd3, d); check("R6 fall cleared", d, 32'h0);
    set_src(49, 1'b1);
    rd_reg(3'd3, d); check("R6 both-edge rise", d, 32'h0002_0000);
    wr_reg(3'd3, 32'h0002_0000);

    // R8: edge and acknowledge in the same cycle
    set_src(50, 1'b0);
    @(negedge clk);
    src_n[50] = 1'b1; wr = 1'b1; addr = 3'd3; wdata = 32'h0004_0000;
    @(negedge clk); wr = 1'b0; wdata = '0;
    rd_reg(3'd3, d); check("R8 capture beats ack", d, 32'h0004_0000);
    wr_reg(3'd3, 32'h0004_0000);
    rd_reg(3'd3, d); check("R7 later ack clears", d, 32'h0);

    // R9: lowest-numbered wins, masking
    wr_reg(3'd0, 32'h0080_0800);   // src 5 (bit 11), src 40 (bit 23)
    set_src(40, 1'b0);
    set_src(5, 1'b0);
    rd_reg(3'd5, d); check("R9 lowest wins", d, 32'd5 << 26);
    wr_reg(3'd0, 32'h0080_0000);
    rd_reg(3'd5, d); check("R9 masked skipped", d, 32'd40 << 26);
    wr_reg(3'd0, 32'h0);
    check("R1 masked no irq", {31'h0, irq}, 32'h0);
    rd_reg(3'd2, d); check("R1 masked still pending", d, 32'h0080_0800);
    set_src(40, 1'b1);
    set_src(5, 1'b1);

    // R11: source 0 reserved
    wr_reg(3'd0, 32'h1);
    set_src(0, 1'b0);
    check("R11 src0 no irq", {31'h0, irq}, 32'h0);
    rd_reg(3'd5, d); check("R11 src0 no vector", d, 32'h0);
    rd_reg(3'd2, d); check("R11 src0 status", d, 32'h1);
    set_src(0, 1'b1);

    // R12: unused addresses
    wr_reg(3'd6, 32'hFFFF_FFFF);
    rd_reg(3'd6, d); check("R12 addr6 zero", d, 32'h0);
    wr_reg(3'd5, 32'hFFFF_FFFF);
    rd_reg(3'd0, d); check("R12 no side effect", d, 32'h1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule